// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block is the front stage of an in-order fetch path for a pipelined processor that has no branch predictor. It holds the program counter and, in each cycle where fetching is allowed, makes one lookup into the instruction cache. On a hit it delivers a group of consecutive 32-bit instruction words to decode. Each word carries its own valid bit, its PC, its predicted next PC and a sequence number. A group stops at the configured fetch width or at the last word of the current cache line, whichever comes first. The predicted path is always the fall-through path.

Later pipeline stages send back redirect (squash) requests and stall requests. The controller resolves them in a fixed priority and moves between six states: idle, running, blocked, squashing, miss-stall and miss-complete. A cache miss parks the stage until the cache signals that the refill is done. A fault on the fetch access blocks the stage and raises a one-cycle trap request. The cache answers in the same cycle as the lookup. The line data, hit and fault flags are plain inputs.

Top module: `ifetch_ctrl`

## Requirements
- R1: After reset, `ctlState` is 0 (idle), `fetchPc` equals `RESET_PC`, `fetchNextPc` equals `RESET_PC`+4, no slot is valid and `trapReq` is low. The stage stays idle until `start` is high at a clock edge. It then enters running (`ctlState`=1) without fetching in that cycle.
- R2: In running, a hit with no feedback active delivers a group on the outputs one cycle after the lookup edge. Slot i holds PC+4i, the line word at word index (PC[5:2]+i), the predicted next PC PC+4i+4, and a valid bit. `icReqValid` is high with `icReqAddr` equal to `fetchPc` in every cycle that makes a lookup, and low in idle.
- R3: A group holds min(FW, words from PC to the end of its line) instructions. Slots past that count are invalid, and `fetchPc` advances to the address right after the last delivered word.
- R4: Sequence numbers run on without a gap across groups. Slot i carries the running count plus i, and the count grows by the group length.
- R5: The feedback priority is commit squash, then decode squash, then ROB-still-squashing, then stalls. A squash loads `fetchPc` with the chosen redirect address and `fetchNextPc` with that address plus 4, enters squashing (`ctlState`=3) and delivers nothing.
- R6: In squashing, the stage stays put while ROB-squashing is high and ignores a decode squash. A new commit squash redirects again. When commit squash and ROB-squashing are both low, the stage returns to running with no delivery in that cycle.
- R7: ROB-squashing alone, seen in running, enters squashing and leaves `fetchPc` unchanged.
- R8: Any of the four stall inputs high in running enters blocked (`ctlState`=2) with `fetchPc` held. The stage stays blocked while any stall is high and returns to running once all four are low. A squash seen in blocked redirects it into squashing.
- R9: A miss on the lookup enters miss-stall (`ctlState`=4) with no delivery and `fetchPc` held. `icMissDone` moves miss-stall to miss-complete (`ctlState`=5). The next cycle looks up again, delivers the group from the line data whatever `icHit` says, and returns to running. `icMissDone` in any other state has no effect.
- R10: A fault on the lookup enters blocked, pulses `trapReq` for exactly one cycle, delivers nothing and holds `fetchPc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Leave idle and begin fetching |
| cmtSquash | input | 1 | Redirect request from commit (highest priority) |
| cmtRedirect | input | AW | Redirect address from commit |
| decSquash | input | 1 | Redirect request from decode |
| decRedirect | input | AW | Redirect address from decode |
| robSquashing | input | 1 | Reorder buffer still draining a squash |
| stallDecode | input | 1 | Stall request from decode |
| stallRename | input | 1 | Stall request from rename |
| stallExecute | input | 1 | Stall request from execute |
| stallCommit | input | 1 | Stall request from commit |
| icReqValid | output | 1 | Cache lookup made this cycle |
| icReqAddr | output | AW | Lookup address (current PC) |
| icHit | input | 1 | Lookup hit, same cycle |
| icFault | input | 1 | Lookup faulted, same cycle |
| icLine | input | LINE_BYTES*8 | Whole cache line, word k at bits 32k+31:32k |
| icMissDone | input | 1 | Outstanding miss has been served |
| grpValid | output | FW | Per-slot valid |
| grpPc | output | FW*AW | Per-slot PC |
| grpNextPc | output | FW*AW | Per-slot predicted next PC |
| grpInst | output | FW*32 | Per-slot instruction word |
| grpSeq | output | FW*SEQW | Per-slot sequence number |
| fetchPc | output | AW | Current fetch PC |
| fetchNextPc | output | AW | Next PC after the current one |
| trapReq | output | 1 | One-cycle fault notification |
| ctlState | output | 3 | Controller state code |

## Verification
A wrong state code shows on `ctlState` at the next sample. It also shows within one cycle as a group delivered when it should have been held back, or held back when it should have been delivered. A mistaken PC advance or a wrong line index surfaces in the next group's slot PCs and instruction words, because the bench cache returns each word as a fixed function of its address. A lost or doubled sequence increment breaks the running count that the bench carries across every group. Each scenario checks the state code, the PC and the slot contents in the cycle after its stimulus.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_SQUASH = 3'd3,
    ST_MISS   = 3'd4,
    ST_MDONE  = 3'd5
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic redirect;  // load PC from a redirect address
    logic useDec;    // redirect source is decode, else commit
    logic deliver;   // latch a fetch group and advance
  } fetchCtl_t;

endpackage

// File: rtl/ifetch_fsm.sv
module ifetch_fsm
  import ifetch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmtSquash,
  input  logic        decSquash,
  input  logic        robSquashing,
  input  logic        anyStall,
  input  logic        icHit,
  input  logic        icFault,
  input  logic        icMissDone,
  output fetchCtl_t   ctl,
  output logic        lookup,
  output fetchState_e state,
  output logic        trapReq
);

  fetchState_e stateNxt;
  logic        trapNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    lookup   = 1'b0;
    trapNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) stateNxt = ST_RUN;
      end
      ST_RUN, ST_MDONE: begin
        if (cmtSquash) begin
          ctl.redirect = 1'b1;
          stateNxt     = ST_SQUASH;
        end else if (decSquash) begin
          ctl.redirect = 1'b1;
          ctl.useDec   = 1'b1;
          stateNxt     = ST_SQUASH;
        end else if (robSquashing) begin
          stateNxt = ST_SQUASH;
        end else if (anyStall) begin
          stateNxt = ST_BLOCK;
        end else begin
          lookup = 1'b1;
          if (state == ST_MDONE) begin
            ctl.deliver = 1'b1;
            stateNxt    = ST_RUN;
          end else if (icFault) begin
            trapNxt  = 1'b1;
            stateNxt = ST_BLOCK;
          end else if (!icHit) begin
            stateNxt = ST_MISS;
          end else begin
            ctl.deliver = 1'b1;
          end
        end
      end
      ST_BLOCK: begin
        stateNxt = anyStall ? ST_BLOCK : ST_RUN;
        if (cmtSquash) begin
          ctl.redirect = 1'b1;
          stateNxt     = ST_SQUASH;
        end else if (decSquash) begin
          ctl.redirect = 1'b1;
          ctl.useDec   = 1'b1;
          stateNxt     = ST_SQUASH;
        end else if (robSquashing) begin
          stateNxt = ST_SQUASH;
        end
      end
      ST_SQUASH: begin
        if (cmtSquash) begin
          ctl.redirect = 1'b1;
        end else if (!robSquashing) begin
          stateNxt = ST_RUN;
        end
      end
      ST_MISS: begin
        if (icMissDone) stateNxt = ST_MDONE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      trapReq <= 1'b0;
    end else begin
      state   <= stateNxt;
      trapReq <= trapNxt;
    end
  end

  // R5
  cmt_squash_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cmtSquash) |=> (state == ST_SQUASH));

  // R6
  squash_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SQUASH && robSquashing) |=> (state == ST_SQUASH));

  // R9
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MISS && !icMissDone) |=> (state == ST_MISS));

  // R10
  trap_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (state == ST_BLOCK));

  // R10
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> !trapReq);

  // R1
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));

endmodule

// File: rtl/ifetch_path.sv
module ifetch_path
  import ifetch_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          FW         = 4,
  parameter int          LINE_BYTES = 64,
  parameter int          SEQW       = 16,
  parameter logic [AW-1:0] RESET_PC = 32'h100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fetchCtl_t               ctl,
  input  logic [AW-1:0]           cmtRedirect,
  input  logic [AW-1:0]           decRedirect,
  input  logic [LINE_BYTES*8-1:0] icLine,
  output logic [FW-1:0]           grpValid,
  output logic [FW*AW-1:0]        grpPc,
  output logic [FW*AW-1:0]        grpNextPc,
  output logic [FW*32-1:0]        grpInst,
  output logic [FW*SEQW-1:0]      grpSeq,
  output logic [AW-1:0]           fetchPc,
  output logic [AW-1:0]           fetchNextPc
);

  localparam int INST_BYTES = 4;
  localparam int SH         = $clog2(INST_BYTES);
  localparam int WPL        = LINE_BYTES / INST_BYTES;
  localparam int OFFW       = $clog2(LINE_BYTES);
  localparam int IDXW       = $clog2(WPL);
  localparam int RW         = IDXW + 1;

  logic [AW-1:0]   pcQ, npcQ;
  logic [SEQW-1:0] seqQ;
  logic [IDXW-1:0] wordIdx;
  logic [RW-1:0]   remain;
  logic [RW-1:0]   grpLen;
  logic [AW-1:0]   redirAddr;
  logic [AW-1:0]   advPc;

  assign wordIdx   = pcQ[OFFW-1:SH];
  assign remain    = RW'(WPL) - {1'b0, wordIdx};
  assign grpLen    = (remain < RW'(FW)) ? remain : RW'(FW);
  assign redirAddr = ctl.useDec ? decRedirect : cmtRedirect;
  assign advPc     = pcQ + (AW'(grpLen) << SH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      npcQ <= RESET_PC + AW'(INST_BYTES);
      seqQ <= '0;
    end else if (ctl.redirect) begin
      pcQ  <= redirAddr;
      npcQ <= redirAddr + AW'(INST_BYTES);
    end else if (ctl.deliver) begin
      pcQ  <= advPc;
      npcQ <= advPc + AW'(INST_BYTES);
      seqQ <= seqQ + SEQW'(grpLen);
    end
  end

  assign fetchPc     = pcQ;
  assign fetchNextPc = npcQ;

  for (genvar i = 0; i < FW; i++) begin : g_slot
    logic [IDXW-1:0] wIdx;
    logic            vQ;
    logic [AW-1:0]   pcS, npcS;
    logic [31:0]     instS;
    logic [SEQW-1:0] seqS;

    assign wIdx = wordIdx + IDXW'(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ    <= 1'b0;
        pcS   <= '0;
        npcS  <= '0;
        instS <= '0;
        seqS  <= '0;
      end else begin
        vQ <= ctl.deliver && (RW'(i) < grpLen);
        if (ctl.deliver) begin
          pcS   <= pcQ + AW'(i * INST_BYTES);
          npcS  <= pcQ + AW'((i + 1) * INST_BYTES);
          instS <= icLine[wIdx*32 +: 32];
          seqS  <= seqQ + SEQW'(i);
        end
      end
    end

    assign grpValid[i]               = vQ;
    assign grpPc[i*AW +: AW]         = pcS;
    assign grpNextPc[i*AW +: AW]     = npcS;
    assign grpInst[i*32 +: 32]       = instS;
    assign grpSeq[i*SEQW +: SEQW]    = seqS;

    if (i > 0) begin : g_thermo
      // R3
      valid_thermo_chk: assert property (@(posedge clk) disable iff (!rstN)
        vQ |-> g_slot[i-1].vQ);
    end
  end

  // R3
  line_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.deliver |=> ((pcQ[AW-1:OFFW] == $past(pcQ[AW-1:OFFW])) ||
                     (pcQ[OFFW-1:0] == '0)));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.deliver |=> (seqQ != $past(seqQ)) &&
                    ((seqQ - $past(seqQ)) <= SEQW'(FW)));

  // R4
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.deliver |=> $stable(seqQ));

endmodule

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          FW         = 4,
  parameter int          LINE_BYTES = 64,
  parameter int          SEQW       = 16,
  parameter logic [AW-1:0] RESET_PC = 32'h100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    cmtSquash,
  input  logic [AW-1:0]           cmtRedirect,
  input  logic                    decSquash,
  input  logic [AW-1:0]           decRedirect,
  input  logic                    robSquashing,
  input  logic                    stallDecode,
  input  logic                    stallRename,
  input  logic                    stallExecute,
  input  logic                    stallCommit,
  output logic                    icReqValid,
  output logic [AW-1:0]           icReqAddr,
  input  logic                    icHit,
  input  logic                    icFault,
  input  logic [LINE_BYTES*8-1:0] icLine,
  input  logic                    icMissDone,
  output logic [FW-1:0]           grpValid,
  output logic [FW*AW-1:0]        grpPc,
  output logic [FW*AW-1:0]        grpNextPc,
  output logic [FW*32-1:0]        grpInst,
  output logic [FW*SEQW-1:0]      grpSeq,
  output logic [AW-1:0]           fetchPc,
  output logic [AW-1:0]           fetchNextPc,
  output logic                    trapReq,
  output logic [2:0]              ctlState
);

  fetchCtl_t   ctl;
  fetchState_e state;
  logic        anyStall;
  logic        lookup;

  assign anyStall = stallDecode | stallRename | stallExecute | stallCommit;

  ifetch_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .cmtSquash    (cmtSquash),
    .decSquash    (decSquash),
    .robSquashing (robSquashing),
    .anyStall     (anyStall),
    .icHit        (icHit),
    .icFault      (icFault),
    .icMissDone   (icMissDone),
    .ctl          (ctl),
    .lookup       (lookup),
    .state        (state),
    .trapReq      (trapReq)
  );

  ifetch_path #(
    .AW         (AW),
    .FW         (FW),
    .LINE_BYTES (LINE_BYTES),
    .SEQW       (SEQW),
    .RESET_PC   (RESET_PC)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cmtRedirect (cmtRedirect),
    .decRedirect (decRedirect),
    .icLine      (icLine),
    .grpValid    (grpValid),
    .grpPc       (grpPc),
    .grpNextPc   (grpNextPc),
    .grpInst     (grpInst),
    .grpSeq      (grpSeq),
    .fetchPc     (fetchPc),
    .fetchNextPc (fetchNextPc)
  );

  assign icReqValid = lookup;
  assign icReqAddr  = fetchPc;
  assign ctlState   = state;

  // R8
  stall_hold_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && anyStall && !cmtSquash && !decSquash && !robSquashing)
      |=> (ctlState == 3'd2) && $stable(fetchPc) && (grpValid == '0));

  // R2
  deliver_after_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && icReqValid && icHit && !icFault) |=> grpValid[0]);

endmodule

// File: tb/sim_ifetch_ctrl.sv
`timescale 1ns/1ps
module sim_ifetch_ctrl;

  localparam int AW = 32, FW = 4, LB = 64, SEQW = 16;
  localparam logic [31:0] RPC = 32'h100;
  localparam logic [31:0] XK  = 32'h5A00_0000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic cmtSquash = 1'b0, decSquash = 1'b0, robSquashing = 1'b0;
  logic [AW-1:0] cmtRedirect = '0, decRedirect = '0;
  logic stallDecode = 1'b0, stallRename = 1'b0, stallExecute = 1'b0, stallCommit = 1'b0;
  logic icHit = 1'b1, icFault = 1'b0, icMissDone = 1'b0;
  logic icReqValid, trapReq;
  logic [AW-1:0] icReqAddr, fetchPc, fetchNextPc;
  logic [LB*8-1:0] icLine;
  logic [FW-1:0] grpValid;
  logic [FW*AW-1:0] grpPc, grpNextPc;
  logic [FW*32-1:0] grpInst;
  logic [FW*SEQW-1:0] grpSeq;
  logic [2:0] ctlState;

  int checks = 0, errors = 0;
  int seqExp = 0;

  always #2.5 clk = ~clk;

  // cache model: each word is its own address xor a constant
  for (genvar k = 0; k < LB/4; k++) begin : g_line
    assign icLine[k*32 +: 32] = {icReqAddr[31:6], 4'(k), 2'b00} ^ XK;
  end

  ifetch_ctrl u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .cmtSquash(cmtSquash), .cmtRedirect(cmtRedirect),
    .decSquash(decSquash), .decRedirect(decRedirect),
    .robSquashing(robSquashing),
    .stallDecode(stallDecode), .stallRename(stallRename),
    .stallExecute(stallExecute), .stallCommit(stallCommit),
    .icReqValid(icReqValid), .icReqAddr(icReqAddr),
    .icHit(icHit), .icFault(icFault), .icLine(icLine), .icMissDone(icMissDone),
    .grpValid(grpValid), .grpPc(grpPc), .grpNextPc(grpNextPc),
    .grpInst(grpInst), .grpSeq(grpSeq),
    .fetchPc(fetchPc), .fetchNextPc(fetchNextPc),
    .trapReq(trapReq), .ctlState(ctlState)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkGroup(input string tag, input logic [31:0] base, input int n);
    for (int i = 0; i < FW; i++) begin
      chk({tag, " valid"}, 64'(grpValid[i]), 64'(i < n));
      if (i < n) begin
        logic [31:0] p;
        p = base + 32'(4*i);
        chk({tag, " pc"}, 64'(grpPc[i*AW +: AW]), 64'(p));
        chk({tag, " npc"}, 64'(grpNextPc[i*AW +: AW]), 64'(p + 32'd4));
        chk({tag, " inst"}, 64'(grpInst[i*32 +: 32]), 64'(p ^ XK));
        chk({tag, " R4 seq"}, 64'(grpSeq[i*SEQW +: SEQW]), 64'(16'(seqExp + i)));
      end
    end
    seqExp += n;
  endtask

  task automatic tReset();
    step(); step();
    chk("R1 state", 64'(ctlState), 64'd0);
    chk("R1 pc", 64'(fetchPc), 64'(RPC));
    chk("R1 npc", 64'(fetchNextPc), 64'(RPC + 32'd4));
    chk("R1 valid", 64'(grpValid), 64'd0);
    chk("R1 trap", 64'(trapReq), 64'd0);
    rstN = 1'b1;
    step();
    chk("R1 idle hold", 64'(ctlState), 64'd0);
    chk("R2 no lookup idle", 64'(icReqValid), 64'd0);
  endtask

  task automatic tStart();
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R1 run", 64'(ctlState), 64'd1);
    chk("R1 no fetch", 64'(grpValid), 64'd0);
    chk("R2 req", 64'(icReqValid), 64'd1);
    chk("R2 addr", 64'(icReqAddr), 64'(RPC));
    step();
    checkGroup("R2 first", RPC, 4);
    chk("R3 pc adv", 64'(fetchPc), 64'(RPC + 32'd16));
  endtask

  task automatic tLineEnd();
    cmtSquash = 1'b1; cmtRedirect = 32'h1038;
    step();
    cmtSquash = 1'b0;
    chk("R5 sq state", 64'(ctlState), 64'd3);
    chk("R5 sq pc", 64'(fetchPc), 64'h1038);
    chk("R5 sq npc", 64'(fetchNextPc), 64'h103C);
    chk("R5 no deliver", 64'(grpValid), 64'd0);
    step();
    chk("R6 exit", 64'(ctlState), 64'd1);
    chk("R6 no deliver", 64'(grpValid), 64'd0);
    step();
    checkGroup("R3 line end", 32'h1038, 2);
    chk("R3 pc next line", 64'(fetchPc), 64'h1040);
    step();
    checkGroup("R3 new line", 32'h1040, 4);
  endtask

  task automatic tPriority();
    cmtSquash = 1'b1; cmtRedirect = 32'h2000;
    decSquash = 1'b1; decRedirect = 32'h3000;
    robSquashing = 1'b1; stallDecode = 1'b1;
    step();
    cmtSquash = 1'b0; stallDecode = 1'b0;
    chk("R5 prio state", 64'(ctlState), 64'd3);
    chk("R5 prio pc", 64'(fetchPc), 64'h2000);
    chk("R5 prio none", 64'(grpValid), 64'd0);
    step();
    chk("R6 hold", 64'(ctlState), 64'd3);
    chk("R6 dec ignored", 64'(fetchPc), 64'h2000);
    cmtSquash = 1'b1; cmtRedirect = 32'h2100;
    step();
    cmtSquash = 1'b0; robSquashing = 1'b0; decSquash = 1'b0;
    chk("R6 re-redirect", 64'(fetchPc), 64'h2100);
    chk("R6 still sq", 64'(ctlState), 64'd3);
    step();
    chk("R6 back run", 64'(ctlState), 64'd1);
    decSquash = 1'b1;
    step();
    decSquash = 1'b0;
    chk("R5 dec state", 64'(ctlState), 64'd3);
    chk("R5 dec pc", 64'(fetchPc), 64'h3000);
    step();
    step();
    checkGroup("R5 after dec", 32'h3000, 4);
  endtask

  task automatic tRob();
    robSquashing = 1'b1;
    step();
    robSquashing = 1'b0;
    chk("R7 state", 64'(ctlState), 64'd3);
    chk("R7 pc held", 64'(fetchPc), 64'h3010);
    chk("R7 none", 64'(grpValid), 64'd0);
    step();
    chk("R7 resume", 64'(ctlState), 64'd1);
  endtask

  task automatic tStall();
    stallRename = 1'b1;
    step();
    stallRename = 1'b0; stallCommit = 1'b1;
    chk("R8 blocked", 64'(ctlState), 64'd2);
    chk("R8 pc held", 64'(fetchPc), 64'h3010);
    chk("R8 none", 64'(grpValid), 64'd0);
    step();
    chk("R8 stay", 64'(ctlState), 64'd2);
    stallCommit = 1'b0; stallExecute = 1'b1;
    step();
    stallExecute = 1'b0;
    chk("R8 stay2", 64'(ctlState), 64'd2);
    step();
    chk("R8 release", 64'(ctlState), 64'd1);
    chk("R8 none on release", 64'(grpValid), 64'd0);
    step();
    checkGroup("R8 resume", 32'h3010, 4);
    stallDecode = 1'b1;
    step();
    cmtSquash = 1'b1; cmtRedirect = 32'h3020;
    chk("R8 blocked again", 64'(ctlState), 64'd2);
    step();
    cmtSquash = 1'b0; stallDecode = 1'b0;
    chk("R8 squash in blocked", 64'(ctlState), 64'd3);
    chk("R8 squash pc", 64'(fetchPc), 64'h3020);
    step();
    chk("R8 to run", 64'(ctlState), 64'd1);
  endtask

  task automatic tMiss();
    icHit = 1'b0;
    step();
    icHit = 1'b1;
    chk("R9 miss state", 64'(ctlState), 64'd4);
    chk("R9 none", 64'(grpValid), 64'd0);
    chk("R9 pc held", 64'(fetchPc), 64'h3020);
    step();
    chk("R9 waits", 64'(ctlState), 64'd4);
    icMissDone = 1'b1;
    step();
    icMissDone = 1'b0;
    icHit = 1'b0;
    chk("R9 complete", 64'(ctlState), 64'd5);
    chk("R9 relookup", 64'(icReqValid), 64'd1);
    step();
    icHit = 1'b1;
    chk("R9 run", 64'(ctlState), 64'd1);
    checkGroup("R9 group", 32'h3020, 4);
    icMissDone = 1'b1;
    step();
    icMissDone = 1'b0;
    chk("R9 done ignored", 64'(ctlState), 64'd1);
    checkGroup("R9 done ignored", 32'h3030, 4);
  endtask

  task automatic tFault();
    icFault = 1'b1;
    step();
    icFault = 1'b0;
    chk("R10 blocked", 64'(ctlState), 64'd2);
    chk("R10 trap", 64'(trapReq), 64'd1);
    chk("R10 none", 64'(grpValid), 64'd0);
    chk("R10 pc held", 64'(fetchPc), 64'h3040);
    step();
    chk("R10 trap pulse", 64'(trapReq), 64'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tStart();
    tLineEnd();
    tPriority();
    tRob();
    tStall();
    tMiss();
    tFault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule